// File: doc/BRIEF.md
# Autocorrelation Failure Monitor

This block watches the results of an autocorrelation health test that runs over and over on an entropy stream. It keeps two counters. One counts how many test runs have begun. The other counts how many of those runs failed. Both counters are packed into one 32-bit statistics word, and software can read it. Any write to that word clears both counters. When either counter reaches its full-scale value, both counters stop moving together. The two values therefore always describe the same window of activity.

The block also tracks how many failures have occurred back to back. A passing result resets that run to zero. When the run reaches the configured limit (four by default), the block raises a one-cycle fatal event and a halt level. The halt level stops the generator. It stays set until the hardware reset, and nothing software can do releases it. A bypass control switches the test off entirely. While bypass is high, the block records nothing. The correlation arithmetic itself sits upstream and is not part of this block.

Top module: `acorr_fail_monitor`

## Requirements
- R1: The statistics word carries the start count in bits 13:0 and the failure count in bits 21:14. Bits 31:22 always read zero.
- R2: While the block is active (not bypassed and not halted), each cycle with `test_start` high raises the start count by one in the following cycle.
- R3: While the block is active, each cycle with `test_done` and `test_fail` both high raises the failure count by one. A cycle with `test_done` high and `test_fail` low leaves the failure count unchanged.
- R4: A cycle with `stat_wr` high sets both counters to zero in the next cycle, whatever the write data. The clear takes precedence over a start or failure in the same cycle.
- R5: Once the start count is 16383 or the failure count is 255, neither counter changes again until a clear or a reset.
- R6: A run of four failed results with no passing result between them ends in a specific way on the cycle after the fourth failure: `fatal_err` is high for exactly one cycle and `halted` rises. A passing result resets the run to zero.
- R7: Once `halted` is set, it stays high until `rst_n` is asserted. While halted, no starts or failures are recorded. A `stat_wr` neither clears `halted` nor resets the run.
- R8: While `bypass` is high, starts and failures leave the counters unchanged, and failures neither extend the run nor cause a fatal event.
- R9: After reset, the statistics word is zero and both `fatal_err` and `halted` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_start | input | 1 | One-cycle pulse: a test run begins |
| test_done | input | 1 | One-cycle pulse: a test run produced a result |
| test_fail | input | 1 | Result qualifier sampled with `test_done`: 1 = failed, 0 = passed |
| bypass | input | 1 | 1 disables the test; nothing is recorded |
| stat_wr | input | 1 | Write strobe to the statistics register; clears both counters |
| stat_word | output | 32 | Packed statistics word |
| fatal_err | output | 1 | One-cycle pulse when the failure run reaches its limit |
| halted | output | 1 | Sticky halt level; cleared only by reset |

## Verification
Two events can arrive in the same cycle: a counter clear and a test event (a start, or the failure that completes the fatal run). The bench drives `stat_wr` together with `test_start` and with the fourth consecutive failure. It then expects both counters to read zero in the next cycle. In the second case it also expects `fatal_err` to pulse and `halted` to rise in that same next cycle. This shows that the clear takes precedence over the statistics but leaves the run tracking and the halt untouched.

// File: rtl/acorr_fail_monitor.sv
module acorr_fail_monitor #(
  parameter int START_W   = 14,
  parameter int FAIL_W    = 8,
  parameter int WORD_W    = 32,
  parameter int RUN_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_start,
  input  logic              test_done,
  input  logic              test_fail,
  input  logic              bypass,
  input  logic              stat_wr,
  output logic [WORD_W-1:0] stat_word,
  output logic              fatal_err,
  output logic              halted
);
  localparam int RUN_W  = $clog2(RUN_LIMIT + 1);
  localparam int PAD_W  = WORD_W - START_W - FAIL_W;
  localparam logic [START_W-1:0] START_MAX = '1;
  localparam logic [FAIL_W-1:0]  FAIL_MAX  = '1;
  localparam logic [RUN_W-1:0]   RUN_LAST  = RUN_W'(RUN_LIMIT - 1);

  logic [START_W-1:0] starts_q;
  logic [FAIL_W-1:0]  fails_q;
  logic [RUN_W-1:0]   run_q;

  wire active   = !bypass && !halted;
  wire frozen   = (starts_q == START_MAX) || (fails_q == FAIL_MAX);
  wire fail_evt = active && test_done && test_fail;
  wire pass_evt = active && test_done && !test_fail;
  wire trip     = fail_evt && (run_q == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      starts_q <= '0;
      fails_q  <= '0;
    end else if (stat_wr) begin
      starts_q <= '0;
      fails_q  <= '0;
    end else if (active && !frozen) begin
      if (test_start) starts_q <= starts_q + 1'b1;
      if (fail_evt)   fails_q  <= fails_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      fatal_err <= 1'b0;
      halted    <= 1'b0;
    end else begin
      fatal_err <= trip;
      if (trip) halted <= 1'b1;
      if (pass_evt) run_q <= '0;
      else if (fail_evt && run_q != RUN_LAST) run_q <= run_q + 1'b1;
    end
  end

  assign stat_word = {{PAD_W{1'b0}}, fails_q, starts_q};

  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[WORD_W-1:START_W+FAIL_W] == '0);

  p_start_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_start && !bypass && !halted && !stat_wr && !frozen)
      |=> stat_word[START_W-1:0] == $past(stat_word[START_W-1:0]) + 1'b1);

  p_pass_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done && !test_fail && !stat_wr)
      |=> $stable(stat_word[START_W+FAIL_W-1:START_W]));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> stat_word == '0);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !stat_wr) |=> $stable(stat_word));

  p_fatal_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> !fatal_err);

  p_fatal_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |-> halted);

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !stat_wr) |=> $stable(stat_word));

  p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !stat_wr) |=> $stable(stat_word) && !fatal_err);
endmodule

// File: tb/sim_acorr_fail_monitor.sv
module sim_acorr_fail_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_start = 0, test_done = 0, test_fail = 0, bypass = 0, stat_wr = 0;
  logic [31:0] stat_word;
  logic fatal_err, halted;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  acorr_fail_monitor u0 (
    .clk(clk), .rst_n(rst_n), .test_start(test_start), .test_done(test_done),
    .test_fail(test_fail), .bypass(bypass), .stat_wr(stat_wr),
    .stat_word(stat_word), .fatal_err(fatal_err), .halted(halted)
  );

  // stimulus {start,done,fail,bypass,wr}, expected {halt,pulse,fails[7:0],starts[13:0]}
  localparam logic [28:0] VEC [0:13] = '{
    {5'b10000, 1'b0, 1'b0, 8'd0, 14'd1},
    {5'b01000, 1'b0, 1'b0, 8'd0, 14'd1},
    {5'b11100, 1'b0, 1'b0, 8'd1, 14'd2},
    {5'b11110, 1'b0, 1'b0, 8'd1, 14'd2},
    {5'b01100, 1'b0, 1'b0, 8'd2, 14'd2},
    {5'b10001, 1'b0, 1'b0, 8'd0, 14'd0},
    {5'b01000, 1'b0, 1'b0, 8'd0, 14'd0},
    {5'b10000, 1'b0, 1'b0, 8'd0, 14'd1},
    {5'b01100, 1'b0, 1'b0, 8'd1, 14'd1},
    {5'b01100, 1'b0, 1'b0, 8'd2, 14'd1},
    {5'b01100, 1'b0, 1'b0, 8'd3, 14'd1},
    {5'b11101, 1'b1, 1'b1, 8'd0, 14'd0},
    {5'b11100, 1'b1, 1'b0, 8'd0, 14'd0},
    {5'b00001, 1'b1, 1'b0, 8'd0, 14'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] s);
    @(negedge clk);
    {test_start, test_done, test_fail, bypass, stat_wr} = s;
    @(posedge clk);
    #1;
    @(negedge clk);
    {test_start, test_done, test_fail, bypass, stat_wr} = 5'b0;
  endtask

  task automatic pulse(input logic [4:0] s);
    @(negedge clk);
    {test_start, test_done, test_fail, bypass, stat_wr} = s;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    {test_start, test_done, test_fail, bypass, stat_wr} = 5'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {test_start, test_done, test_fail, bypass, stat_wr} = 5'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R9 reset word", stat_word, 32'h0);
    chk("R9 reset halt/fatal", {30'b0, halted, fatal_err}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      pulse(VEC[i][28:24]);
      chk($sformatf("R1 R2 R3 R4 R8 vec%0d word", i), stat_word,
          {10'b0, VEC[i][21:0]});
      chk($sformatf("R6 R7 vec%0d halt/fatal", i), {30'b0, halted, fatal_err},
          {30'b0, VEC[i][23], VEC[i][22]});
    end
    idle();
    chk("R6 fatal one cycle", {31'b0, fatal_err}, 32'h0);
    chk("R7 halt held", {31'b0, halted}, 32'h1);

    do_reset();
    chk("R9 reset clears halt", {31'b0, halted}, 32'h0);

    // bypass blocks a fatal run
    for (int k = 0; k < 5; k++) step(5'b01110);
    chk("R8 bypass no halt", {31'b0, halted}, 32'h0);
    chk("R8 bypass no count", stat_word, 32'h0);

    // pass breaks the run
    step(5'b01100); step(5'b01100); step(5'b01100);
    step(5'b01000);
    step(5'b01100); step(5'b01100); step(5'b01100);
    chk("R6 pass resets run", {31'b0, halted}, 32'h0);
    chk("R3 failure count", stat_word, {10'b0, 8'd6, 14'd0});

    // start counter saturation freezes both
    step(5'b00001);
    @(negedge clk);
    test_start = 1'b1;
    repeat (16383) @(posedge clk);
    #1;
    idle();
    chk("R5 start full", stat_word, {18'b0, 14'h3fff});
    step(5'b11000);
    chk("R5 frozen by starts", stat_word, {18'b0, 14'h3fff});
    step(5'b00001);
    step(5'b10000);
    chk("R4 clear resumes", stat_word, 32'h1);

    // failure counter saturation freezes starts
    do_reset();
    for (int k = 0; k < 255; k++) begin
      step(5'b01100);
      if (k % 3 == 2) step(5'b01000);
    end
    chk("R5 fail full", stat_word, {10'b0, 8'hff, 14'd0});
    step(5'b10000);
    chk("R5 frozen by fails", stat_word, {10'b0, 8'hff, 14'd0});
    chk("R7 no halt during sat", {31'b0, halted}, 32'h0);

    finish_run();
  end
endmodule